// File: doc/BRIEF.md
# Selectable Trigger Source with Pulsers

This block produces a trigger pulse stream from up to three sources. The first is an external level input, brought through a synchronizer and reduced to a one-cycle pulse on each rising edge. The second is a fixed-rate pulser with a 32-bit period. The third is a pseudo-random pulser that compares a free-running 32-bit LFSR against a 32-bit probability threshold. A source-select word turns each source on or off, and the enabled sources are ORed together.

The ORed trigger is held off while any busy (xoff) input is high and also unmasked. A trigger that gets past this gate goes into one registered output stage. That stage drives a per-channel trigger vector through an output mask, and a single trigger-state bit that does not depend on the mask. A registered copy of the raw busy inputs is provided for status. Trigger pulses cannot be delayed, so the trigger outputs have no ready signal and no back-pressure: each pulse lasts exactly one clock and is either delivered or dropped. All configuration pins are plain levels, normally driven from registers elsewhere on the chip.

Top module: `trig_source_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, `trig_out` is all zeros and `trig_state` is 0.
- R2: A rising edge on `ext_in`, when `src_sel` bit 0 is set, gives exactly one trigger cycle. That cycle appears in the third clock cycle after the edge is first sampled (two synchronizer stages plus the output register). Holding `ext_in` high does not produce any further triggers.
- R3: When `src_sel` bit 15 is set and the period P = {`period_hi`,`period_lo`} is nonzero, the fixed pulser fires once every P+1 cycles. When P is zero, it never fires.
- R4: When `src_sel` bit 14 is set, the random pulser fires in every cycle where the LFSR value is below the threshold {`prob_hi`,`prob_lo`}. A threshold of 0 never fires. A threshold of 0xFFFFFFFF fires in practically every cycle. A threshold of 0x80000000 fires in about half of the cycles.
- R5: The enabled sources are ORed together. A source whose select bit is clear adds nothing. Bits 1 to 13 of `src_sel` have no effect.
- R6: If `xoff_in & xoff_mask` is nonzero in the cycle before the output register updates, then `trig_out` is zero and `trig_state` is 0 in the next cycle.
- R7: In each cycle, `trig_out` equals `out_mask` (as sampled at the updating edge) when a trigger passes the gate, and is zero otherwise.
- R8: `trig_state` is 1 exactly when a trigger passed the gate at the last edge. It is independent of `out_mask`.
- R9: `xoff_state` is `xoff_in` delayed by one clock.
- R10: The LFSR never holds the all-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 1 | Asynchronous external trigger level |
| src_sel | input | 16 | Source enables: bit 0 external, bit 14 random, bit 15 fixed |
| period_lo | input | 16 | Fixed pulser period, bits 15:0 |
| period_hi | input | 16 | Fixed pulser period, bits 31:16 |
| prob_lo | input | 16 | Random threshold, bits 15:0 |
| prob_hi | input | 16 | Random threshold, bits 31:16 |
| xoff_in | input | NUM_XOFF | Busy inputs |
| xoff_mask | input | NUM_XOFF | Enables for the busy inputs (1 = honoured) |
| out_mask | input | NUM_OUT | Per-channel output enables |
| trig_out | output | NUM_OUT | Masked trigger pulses |
| trig_state | output | 1 | Gated trigger before the output mask |
| xoff_state | output | NUM_XOFF | Registered raw busy inputs |

## Verification
The bench checks the exact gap between fixed pulses for several short periods and confirms that a zero period stays silent; an off-by-one counter would show up as a gap of P or P+2. It feeds random busy, busy-mask and output-mask patterns while the random source fires every cycle. A gate that ignored the mask, or used the raw busy bits, would block or pass the wrong cycles. It checks the external edge at its exact latency and with the input held high, so a level-sensitive or unsynchronized path would trigger repeatedly or at the wrong cycle. It also checks the random pulser at the threshold extremes and at mid-range, where a swapped half would distort the firing rate.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
  localparam int HALF_W        = 16;
  localparam int WORD_W        = 2 * HALF_W;
  localparam int SEL_EXT_BIT   = 0;
  localparam int SEL_RAND_BIT  = 14;
  localparam int SEL_FIXED_BIT = 15;
  localparam logic [WORD_W-1:0] LFSR_TAPS = 32'h8020_0003;

  typedef struct packed {
    logic fixed_hit;
    logic rand_hit;
    logic ext_hit;
  } src_hits_t;
endpackage

// File: rtl/trig_ext_edge.sv
module trig_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], din};
      prev_q <= sync_q[TOP];
    end
  end

  assign pulse = sync_q[TOP] & ~prev_q;

  // R2
  ext_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/trig_fixed_pulser.sv
module trig_fixed_pulser #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period,
  output logic         pulse
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (period != '0) && (cnt_q >= period);
  assign pulse  = at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || period == '0 || at_end) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  // R3
  fixed_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && period != '0) |=> !pulse);
endmodule

// File: rtl/trig_rand_pulser.sv
module trig_rand_pulser
  import trig_sel_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 32'h1D2C_3B4A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] threshold,
  output logic              pulse
);
  logic [WORD_W-1:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? LFSR_TAPS : '0);
  end

  assign pulse = lfsr_q < threshold;

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  // R4
  rand_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (threshold == '0) |-> !pulse);
endmodule

// File: rtl/trig_source_sel.sv
module trig_source_sel
  import trig_sel_pkg::*;
#(
  parameter int NUM_XOFF    = 8,
  parameter int NUM_OUT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_in,
  input  logic [HALF_W-1:0]   src_sel,
  input  logic [HALF_W-1:0]   period_lo,
  input  logic [HALF_W-1:0]   period_hi,
  input  logic [HALF_W-1:0]   prob_lo,
  input  logic [HALF_W-1:0]   prob_hi,
  input  logic [NUM_XOFF-1:0] xoff_in,
  input  logic [NUM_XOFF-1:0] xoff_mask,
  input  logic [NUM_OUT-1:0]  out_mask,
  output logic [NUM_OUT-1:0]  trig_out,
  output logic                trig_state,
  output logic [NUM_XOFF-1:0] xoff_state
);
  src_hits_t hits;
  logic      ext_p, fixed_p, rand_p;
  logic      any_src, blocked, pass;

  trig_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .din(ext_in), .pulse(ext_p));

  trig_fixed_pulser #(.W(WORD_W)) u_fixed (
    .clk(clk), .rst_n(rst_n), .period({period_hi, period_lo}), .pulse(fixed_p));

  trig_rand_pulser u_rand (
    .clk(clk), .rst_n(rst_n), .threshold({prob_hi, prob_lo}), .pulse(rand_p));

  assign hits.ext_hit   = ext_p   & src_sel[SEL_EXT_BIT];
  assign hits.rand_hit  = rand_p  & src_sel[SEL_RAND_BIT];
  assign hits.fixed_hit = fixed_p & src_sel[SEL_FIXED_BIT];
  assign any_src        = |hits;
  assign blocked        = |(xoff_in & xoff_mask);
  assign pass           = any_src & ~blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_state <= 1'b0;
      xoff_state <= '0;
    end else begin
      trig_state <= pass;
      xoff_state <= xoff_in;
    end
  end

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) trig_out[ch] <= 1'b0;
      else        trig_out[ch] <= pass & out_mask[ch];
    end
  end

  // R6
  xoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(xoff_in & xoff_mask)) |=> (trig_out == '0 && !trig_state));
  // R7
  out_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((trig_out & ~$past(out_mask)) == '0));
  // R8
  out_needs_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out != '0) |-> trig_state);
  // R9
  xoff_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (xoff_state == $past(xoff_in)));
endmodule

// File: tb/trig_source_sel_tb.sv
module trig_source_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NX = 8;
  localparam int NO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_in = 1'b0;
  logic [15:0]   src_sel = '0, period_lo = '0, period_hi = '0, prob_lo = '0, prob_hi = '0;
  logic [NX-1:0] xoff_in = '0, xoff_mask = '0;
  logic [NO-1:0] out_mask = '0;
  logic [NO-1:0] trig_out;
  logic          trig_state;
  logic [NX-1:0] xoff_state;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_source_sel #(.NUM_XOFF(NX), .NUM_OUT(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .src_sel(src_sel),
    .period_lo(period_lo), .period_hi(period_hi), .prob_lo(prob_lo), .prob_hi(prob_hi),
    .xoff_in(xoff_in), .xoff_mask(xoff_mask), .out_mask(out_mask),
    .trig_out(trig_out), .trig_state(trig_state), .xoff_state(xoff_state));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] exp_out(input logic fire, input logic [NX-1:0] xi,
                                            input logic [NX-1:0] xm, input logic [NO-1:0] om);
    return (fire && (xi & xm) == '0) ? om : '0;
  endfunction

  task automatic quiet_cycles(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig_state || trig_out != '0) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(trig_out == '0 && !trig_state, "R1", {trig_out, 7'd0, trig_state}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig_out == '0 && !trig_state, "R1", {trig_out, 7'd0, trig_state}, 0);

    // R2: external edge latency and single pulse
    out_mask = 8'hA5;
    src_sel  = 16'h0001;
    repeat (4) @(negedge clk);
    ext_in = 1'b1;
    @(negedge clk); check(trig_out == '0, "R2", trig_out, 0);
    @(negedge clk); check(trig_out == '0, "R2", trig_out, 0);
    @(negedge clk); check(trig_out == 8'hA5 && trig_state, "R2", trig_out, 8'hA5);
    @(negedge clk); check(trig_out == '0, "R2", trig_out, 0);
    quiet_cycles(20, "R2 held high");
    ext_in = 1'b0;
    repeat (4) @(negedge clk);

    // R5: external edge with its select bit clear, unrelated bits set
    src_sel = 16'h3FFE;
    ext_in = 1'b1;
    quiet_cycles(10, "R5 ext disabled");
    ext_in = 1'b0;
    src_sel = 16'h0000;
    repeat (4) @(negedge clk);

    // R3: fixed pulser gaps
    out_mask = '1;
    for (int t = 0; t < 4; t++) begin
      int p;
      int last;
      int seen;
      int cyc;
      p = (t == 0) ? 1 : 2 + ($urandom % 39);
      period_hi = 16'h0;
      period_lo = 16'(p);
      src_sel   = 16'h8000;
      last = -1; seen = 0; cyc = 0;
      while (seen < 4) begin
        @(negedge clk);
        cyc++;
        if (trig_state) begin
          if (last >= 0) check(cyc - last == p + 1, "R3 gap", cyc - last, p + 1);
          last = cyc;
          seen++;
        end
        if (cyc > 200) begin
          check(0, "R3 no pulse", seen, 4);
          seen = 4;
        end
      end
    end
    period_lo = 16'h0;
    quiet_cycles(100, "R3 zero period");
    // R5: fixed pulser with select bit clear
    period_lo = 16'd3;
    src_sel = 16'h7FFF & ~16'h4001;
    quiet_cycles(50, "R5 fixed disabled");
    period_lo = 16'h0;
    src_sel = 16'h0;

    // R4: random pulser extremes and mid-range
    src_sel = 16'h4000;
    prob_hi = 16'h0; prob_lo = 16'h0;
    quiet_cycles(300, "R4 zero threshold");
    prob_hi = 16'hFFFF; prob_lo = 16'hFFFF;
    @(negedge clk);
    begin
      int hits = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (trig_state) hits++;
      end
      check(hits == 200, "R4 full threshold", hits, 200);
      hits = 0;
      prob_hi = 16'h8000; prob_lo = 16'h0000;
      @(negedge clk);
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (trig_state) hits++;
      end
      check(hits > 700 && hits < 1300, "R4 half threshold", hits, 1000);
    end

    // R6 R7 R8 R9: random gating and masking with the random source always firing
    prob_hi = 16'hFFFF; prob_lo = 16'hFFFF;
    for (int i = 0; i < 300; i++) begin
      logic [NX-1:0] xi, xm;
      logic [NO-1:0] om, e;
      xi = NX'($urandom);
      xm = (i % 3 == 0) ? '0 : NX'($urandom & $urandom);
      om = NO'($urandom);
      xoff_in = xi; xoff_mask = xm; out_mask = om;
      src_sel = 16'h4000 | (16'($urandom) & 16'h3FFE);
      e = exp_out(1'b1, xi, xm, om);
      @(negedge clk);
      check(trig_out == e, "R7 R6 output", trig_out, e);
      check(trig_state == ((xi & xm) == '0), "R8 state", trig_state, (xi & xm) == '0);
      check(xoff_state == xi, "R9 xoff status", xoff_state, xi);
    end

    // R6: single unmasked busy bit blocks; masked one does not
    xoff_in = 8'h10; xoff_mask = 8'h10; out_mask = 8'hFF;
    @(negedge clk); check(trig_out == '0, "R6 blocked", trig_out, 0);
    xoff_mask = 8'hEF;
    @(negedge clk); check(trig_out == 8'hFF, "R6 masked busy", trig_out, 8'hFF);
    // R8: state set even with an empty output mask
    out_mask = '0;
    @(negedge clk); check(trig_state && trig_out == '0, "R8 empty mask", {trig_out, 7'd0, trig_state}, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule